// File: doc/BRIEF.md
# Dot Clock PLL Divider Search

This block works out the divider settings for a pixel-clock synthesiser that runs from a fixed 14,318,180 Hz reference. A target pixel frequency in hertz is presented together with a one-cycle start pulse. The engine first checks that the target is legal. It then doubles the target until the value lands in the oscillator's working band, and records how many doublings it made. Next it sweeps every allowed reference divider n. For each n it finds the feedback divider m that brings the synthesised frequency closest to the target from below, and it keeps the candidate with the smallest frequency error. When the sweep ends it packs the winner into three register-ready bytes and pulses `done`.

The sequencing is one state machine with these states:
- `S_IDLE` waits for `start`, and on it goes to `S_CHECK`.
- `S_CHECK` goes to `S_DONE` for an illegal target, otherwise to `S_PRESCALE`.
- `S_PRESCALE` loops while the scaled target is below the band floor, then goes to `S_DIVIDE`.
- `S_DIVIDE` loops, removing one reference per cycle, to form the integer ratio and the remainder. It then goes to `S_WARM`.
- `S_WARM` steps the candidate up from n=0 to the first legal n, then goes to `S_SWEEP`.
- `S_SWEEP` scores one n per cycle until the last n, then goes to `S_PACK`.
- `S_PACK` encodes the result and goes to `S_DONE`.
- `S_DONE` raises `done` for one cycle and returns to `S_IDLE`.

The feedback divider m for each n is kept up to date incrementally, so no divider runs inside the sweep. A legal request takes roughly 270 to 290 cycles.

Top module: `dclk_pll_search`

## Requirements
- R1: A target above 220,000,000 Hz or below 3,125,000 Hz ends with `done` high, `range_err`=1 and `m_code`, `n_code` and `div_code` all 0. Both bound values themselves are legal, and a legal request ends with `range_err`=0.
- R2: Before the search, the target is doubled until it is at least 100,000,000 Hz. Each doubling adds 0x10 to `div_code`, so bits [7:4] hold the doubling count.
- R3: n takes every value from 3 to 257 inclusive. For each n, the candidate m is floor(n × F / 14,318,180), where F is the doubled target.
- R4: If 3 ≤ m ≤ 257, the candidate's error is n × F − 14,318,180 × m.
- R5: Otherwise, if m ≤ 1028, the error is n × F − 14,318,180 × (m with its two low bits cleared). A candidate whose m exceeds 1028 is skipped.
- R6: A candidate replaces the best so far only when its error is strictly smaller, so on a tie the smaller n wins.
- R7: If the best m exceeds 257, `m_code` = floor(best m / 4) − 2 and `div_code` bit 2 = 0. Otherwise `m_code` = best m − 2 and `div_code` bit 2 = 1. `div_code` bits 3, 1 and 0 are always 0.
- R8: `n_code` = best n − 2.
- R9: `done` is high for exactly one cycle per accepted request. `range_err` and the codes are valid in that cycle and hold until the next request is accepted.
- R10: `start` is accepted only in the idle state. A pulse during a search changes neither the running result nor the number of `done` pulses.
- R11: After reset, `done`, `range_err`, `m_code`, `n_code` and `div_code` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request pulse, taken only when idle |
| target_hz | input | 32 | Target pixel frequency in Hz, sampled with `start` |
| done | output | 1 | One-cycle completion pulse |
| range_err | output | 1 | Target was outside the legal range |
| m_code | output | 8 | Feedback divider code (m − 2 after the loop-divide adjustment) |
| n_code | output | 8 | Reference divider code (n − 2) |
| div_code | output | 8 | Post-divide count in [7:4], loop-divide-by-one select in bit 2 |

## Verification
Some properties are checked by assertions on every cycle:
- `done` never lasts two cycles.
- An illegal target always lands in the error outcome.
- The scaled target always sits inside the oscillator band when division starts.
- The running residual stays below the reference and n stays inside its sweep limits.
- The best error never grows during the sweep.
- The shape of `div_code` is legal whenever a result is reported.

The rest needs the bench's scenarios, in which a separate model recomputes the whole search by direct division:
- that the selected m and n are the true minimum-error pair, with the tie rule;
- that the times-four range and its truncation behave correctly;
- that the doubling count is right;
- that a `start` arriving mid-search leaves the result untouched and produces no extra `done`.

// File: rtl/dclk_pkg.sv
package dclk_pkg;

    localparam int unsigned CODE_W = 8;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CHECK,
        S_PRESCALE,
        S_DIVIDE,
        S_WARM,
        S_SWEEP,
        S_PACK,
        S_DONE
    } srch_state_e;

endpackage

// File: rtl/dclk_range_check.sv
module dclk_range_check #(
    parameter int unsigned FREQ_W = 32,
    parameter int unsigned F_MIN  = 3125000,
    parameter int unsigned F_MAX  = 220000000
) (
    input  logic [FREQ_W-1:0] freq,
    output logic              legal
);
    always_comb begin
        legal = (freq >= FREQ_W'(F_MIN)) && (freq <= FREQ_W'(F_MAX));
    end
endmodule

// File: rtl/dclk_step.sv
module dclk_step #(
    parameter int unsigned FREQ_W = 32,
    parameter int unsigned N_W    = 9,
    parameter int unsigned M_W    = 13,
    parameter int unsigned Q_W    = 5,
    parameter int unsigned REF_HZ = 14318180
) (
    input  logic [N_W-1:0]    n_in,
    input  logic [M_W-1:0]    m_in,
    input  logic [FREQ_W-1:0] r_in,
    input  logic [Q_W-1:0]    ratio,
    input  logic [FREQ_W-1:0] rem,
    output logic [N_W-1:0]    n_out,
    output logic [M_W-1:0]    m_out,
    output logic [FREQ_W-1:0] r_out
);
    localparam logic [FREQ_W:0] REF_X = (FREQ_W+1)'(REF_HZ);

    logic [FREQ_W:0] sum;
    logic            wrap;

    always_comb begin
        sum   = {1'b0, r_in} + {1'b0, rem};
        wrap  = (sum >= REF_X);
        r_out = wrap ? FREQ_W'(sum - REF_X) : FREQ_W'(sum);
        m_out = m_in + M_W'(ratio) + M_W'(wrap);
        n_out = n_in + N_W'(1);
    end
endmodule

// File: rtl/dclk_cost.sv
module dclk_cost #(
    parameter int unsigned FREQ_W  = 32,
    parameter int unsigned M_W     = 13,
    parameter int unsigned ERR_W   = 32,
    parameter int unsigned REF_HZ  = 14318180,
    parameter int unsigned M_LO    = 3,
    parameter int unsigned M_HI    = 257,
    parameter int unsigned M_X4_HI = 1028
) (
    input  logic [M_W-1:0]    m,
    input  logic [FREQ_W-1:0] resid,
    output logic              usable,
    output logic [ERR_W-1:0]  cost
);
    localparam logic [ERR_W-1:0] REF_E  = ERR_W'(REF_HZ);
    localparam logic [ERR_W-1:0] REF_E2 = ERR_W'(REF_HZ) << 1;

    logic direct;
    logic coarse;

    always_comb begin
        direct = (m >= M_W'(M_LO)) && (m <= M_W'(M_HI));
        coarse = !direct && (m <= M_W'(M_X4_HI));
        usable = direct || coarse;
        cost   = ERR_W'(resid);
        if (coarse) begin
            cost = ERR_W'(resid) + (m[1] ? REF_E2 : '0) + (m[0] ? REF_E : '0);
        end
    end
endmodule

// File: rtl/dclk_pll_search.sv
module dclk_pll_search
    import dclk_pkg::*;
#(
    parameter int unsigned FREQ_W   = 32,
    parameter int unsigned REF_HZ   = 14318180,
    parameter int unsigned F_MIN    = 3125000,
    parameter int unsigned F_MAX    = 220000000,
    parameter int unsigned VCO_MIN  = 100000000,
    parameter int unsigned N_LO     = 3,
    parameter int unsigned N_HI     = 257,
    parameter int unsigned M_LO     = 3,
    parameter int unsigned M_HI     = 257,
    parameter int unsigned M_X4_HI  = 1028,
    parameter int unsigned DIV_STEP = 16,
    parameter int unsigned LOOP1    = 4,
    parameter int unsigned ENC_OFS  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [FREQ_W-1:0] target_hz,
    output logic              done,
    output logic              range_err,
    output logic [CODE_W-1:0] m_code,
    output logic [CODE_W-1:0] n_code,
    output logic [CODE_W-1:0] div_code
);
    function automatic int unsigned count_dbl(input int unsigned lo, input int unsigned tgt);
        longint unsigned v;
        int unsigned     c;
        v = lo;
        c = 0;
        while (v < tgt) begin
            v = v << 1;
            c = c + 1;
        end
        return c;
    endfunction

    localparam int unsigned ERR_W   = FREQ_W;
    localparam int unsigned Q_W     = $clog2(F_MAX / REF_HZ + 2);
    localparam int unsigned N_W     = $clog2(N_HI + 2);
    localparam int unsigned M_W     = $clog2(N_HI * (F_MAX / REF_HZ + 1) + 1);
    localparam int unsigned MAX_DBL = count_dbl(F_MIN, VCO_MIN);
    localparam logic [FREQ_W-1:0] REF_F = FREQ_W'(REF_HZ);

    srch_state_e state, state_nx;

    logic [FREQ_W-1:0] f_scaled;
    logic [CODE_W-1:0] div_acc;
    logic [Q_W-1:0]    quo;
    logic [FREQ_W-1:0] rem_q;
    logic [N_W-1:0]    n_q;
    logic [M_W-1:0]    m_q;
    logic [FREQ_W-1:0] r_q;
    logic [ERR_W-1:0]  best_err;
    logic [N_W-1:0]    best_n;
    logic [M_W-1:0]    best_m;
    logic [CODE_W-1:0] m_code_q, n_code_q, div_code_q;
    logic              err_q;

    logic              legal;
    logic [N_W-1:0]    n_nx;
    logic [M_W-1:0]    m_nx;
    logic [FREQ_W-1:0] r_nx;
    logic              usable;
    logic [ERR_W-1:0]  cost;

    dclk_range_check #(
        .FREQ_W (FREQ_W),
        .F_MIN  (F_MIN),
        .F_MAX  (F_MAX)
    ) u_range (
        .freq  (f_scaled),
        .legal (legal)
    );

    dclk_step #(
        .FREQ_W (FREQ_W),
        .N_W    (N_W),
        .M_W    (M_W),
        .Q_W    (Q_W),
        .REF_HZ (REF_HZ)
    ) u_step (
        .n_in  (n_q),
        .m_in  (m_q),
        .r_in  (r_q),
        .ratio (quo),
        .rem   (rem_q),
        .n_out (n_nx),
        .m_out (m_nx),
        .r_out (r_nx)
    );

    dclk_cost #(
        .FREQ_W  (FREQ_W),
        .M_W     (M_W),
        .ERR_W   (ERR_W),
        .REF_HZ  (REF_HZ),
        .M_LO    (M_LO),
        .M_HI    (M_HI),
        .M_X4_HI (M_X4_HI)
    ) u_cost (
        .m      (m_q),
        .resid  (r_q),
        .usable (usable),
        .cost   (cost)
    );

    // Next-state selection
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:     if (start) state_nx = S_CHECK;
            S_CHECK:    state_nx = legal ? S_PRESCALE : S_DONE;
            S_PRESCALE: if (f_scaled >= FREQ_W'(VCO_MIN)) state_nx = S_DIVIDE;
            S_DIVIDE:   if (rem_q < REF_F) state_nx = S_WARM;
            S_WARM:     if (n_q == N_W'(N_LO - 1)) state_nx = S_SWEEP;
            S_SWEEP:    if (n_q == N_W'(N_HI)) state_nx = S_PACK;
            S_PACK:     state_nx = S_DONE;
            S_DONE:     state_nx = S_IDLE;
            default:    state_nx = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // Datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            f_scaled   <= '0;
            div_acc    <= '0;
            quo        <= '0;
            rem_q      <= '0;
            n_q        <= '0;
            m_q        <= '0;
            r_q        <= '0;
            best_err   <= '1;
            best_n     <= '0;
            best_m     <= '0;
            m_code_q   <= '0;
            n_code_q   <= '0;
            div_code_q <= '0;
            err_q      <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (start) begin
                        f_scaled <= target_hz;
                        div_acc  <= '0;
                    end
                end
                S_CHECK: begin
                    err_q <= !legal;
                    if (!legal) begin
                        m_code_q   <= '0;
                        n_code_q   <= '0;
                        div_code_q <= '0;
                    end
                end
                S_PRESCALE: begin
                    if (f_scaled < FREQ_W'(VCO_MIN)) begin
                        f_scaled <= f_scaled << 1;
                        div_acc  <= div_acc + CODE_W'(DIV_STEP);
                    end else begin
                        rem_q <= f_scaled;
                        quo   <= '0;
                    end
                end
                S_DIVIDE: begin
                    if (rem_q >= REF_F) begin
                        rem_q <= rem_q - REF_F;
                        quo   <= quo + Q_W'(1);
                    end else begin
                        n_q      <= '0;
                        m_q      <= '0;
                        r_q      <= '0;
                        best_err <= '1;
                        best_n   <= '0;
                        best_m   <= '0;
                    end
                end
                S_WARM: begin
                    n_q <= n_nx;
                    m_q <= m_nx;
                    r_q <= r_nx;
                end
                S_SWEEP: begin
                    if (usable && (cost < best_err)) begin
                        best_err <= cost;
                        best_n   <= n_q;
                        best_m   <= m_q;
                    end
                    n_q <= n_nx;
                    m_q <= m_nx;
                    r_q <= r_nx;
                end
                S_PACK: begin
                    if (best_m > M_W'(M_HI)) begin
                        m_code_q   <= CODE_W'((best_m >> 2) - M_W'(ENC_OFS));
                        div_code_q <= div_acc;
                    end else begin
                        m_code_q   <= CODE_W'(best_m - M_W'(ENC_OFS));
                        div_code_q <= div_acc | CODE_W'(LOOP1);
                    end
                    n_code_q <= CODE_W'(best_n - N_W'(ENC_OFS));
                end
                S_DONE: begin
                end
                default: begin
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        done      = (state == S_DONE);
        range_err = err_q;
        m_code    = m_code_q;
        n_code    = n_code_q;
        div_code  = div_code_q;
    end

    // R9: completion is a single-cycle pulse
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R1: an illegal latched target must end in the error outcome
    a_r1_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_CHECK && (f_scaled > FREQ_W'(F_MAX) || f_scaled < FREQ_W'(F_MIN)))
        |=> (done && range_err));

    // R2: the scaled target sits in the oscillator band once division starts
    a_r2_vco_band: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DIVIDE) |-> (f_scaled >= FREQ_W'(VCO_MIN) && f_scaled <= FREQ_W'(F_MAX)));

    // R3: residual stays below the reference and n stays in its sweep limits
    a_r3_residual: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_SWEEP) |-> (r_q < REF_F && n_q >= N_W'(N_LO) && n_q <= N_W'(N_HI)));

    // R6: the kept error never grows during the sweep
    a_r6_best_monotone: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_SWEEP && $past(state == S_SWEEP)) |-> (best_err <= $past(best_err)));

    // R7: div_code shape on a legal result
    a_r7_div_shape: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !range_err) |-> (div_code[3] == 1'b0 && div_code[1:0] == 2'b00
                                  && (int'(div_code) / DIV_STEP) <= MAX_DBL));

    // R10: a start pulse during the sweep leaves the scaled target alone
    a_r10_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == S_SWEEP || state == S_WARM) && start) |=> $stable(f_scaled));

endmodule

// File: tb/sim_dclk_pll_search.sv
`timescale 1ns/1ps
module sim_dclk_pll_search;

    localparam longint unsigned REF = 64'd14318180;

    typedef struct packed {
        logic       err;
        logic [7:0] m;
        logic [7:0] n;
        logic [7:0] d;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] target_hz = '0;
    logic        done;
    logic        range_err;
    logic [7:0]  m_code, n_code, div_code;

    int   checks = 0;
    int   fails = 0;
    int   launches = 0;
    int   done_seen = 0;
    exp_t sb[$];

    always #2 clk = ~clk;

    dclk_pll_search u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .target_hz (target_hz),
        .done      (done),
        .range_err (range_err),
        .m_code    (m_code),
        .n_code    (n_code),
        .div_code  (div_code)
    );

    function automatic exp_t model(input longint unsigned f);
        exp_t            e;
        longint unsigned fs, be, bm, bn, m, er, nn;
        logic [7:0]      d;
        logic            ok;
        e = '0;
        if (f > 64'd220000000 || f < 64'd3125000) begin
            e.err = 1'b1;
            return e;
        end
        fs = f;
        d  = 8'h00;
        while (fs < 64'd100000000) begin
            fs = fs << 1;
            d  = d + 8'h10;
        end
        be = 64'hFFFF_FFFF;
        bm = 0;
        bn = 0;
        for (int n = 3; n <= 257; n++) begin
            nn = longint'(n);
            m  = (nn * fs) / REF;
            ok = 1'b1;
            er = 0;
            if (m >= 3 && m <= 257)  er = nn * fs - REF * m;
            else if (m <= 1028)      er = nn * fs - REF * (m & ~64'd3);
            else                     ok = 1'b0;
            if (ok && er < be) begin
                be = er;
                bm = m;
                bn = nn;
            end
        end
        if (bm > 257) bm = bm >> 2;
        else          d  = d | 8'h04;
        e.m = 8'(bm - 2);
        e.n = 8'(bn - 2);
        e.d = d;
        return e;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic launch(input int unsigned f);
        sb.push_back(model(longint'(f)));
        launches++;
        @(negedge clk);
        target_hz = f;
        start     = 1'b1;
        @(negedge clk);
        start     = 1'b0;
    endtask

    task automatic drain();
        while (sb.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // Monitor: pops the scoreboard on each done pulse
    initial begin
        logic prev_done;
        exp_t e;
        prev_done = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (prev_done) chk("R9 done width", int'(done), 0);
                if (done) begin
                    done_seen++;
                    if (sb.size() == 0) begin
                        chk("R10 unexpected done", 1, 0);
                    end else begin
                        e = sb.pop_front();
                        chk("R1 range_err", int'(range_err), int'(e.err));
                        chk("R4 R5 R7 m_code", int'(m_code), int'(e.m));
                        chk("R3 R6 R8 n_code", int'(n_code), int'(e.n));
                        chk("R2 R7 div_code", int'(div_code), int'(e.d));
                    end
                end
                prev_done = done;
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL R9 watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R11: reset values
        chk("R11 done", int'(done), 0);
        chk("R11 range_err", int'(range_err), 0);
        chk("R11 m_code", int'(m_code), 0);
        chk("R11 n_code", int'(n_code), 0);
        chk("R11 div_code", int'(div_code), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        launch(32'd25175000);  drain();
        launch(32'd3125000);   drain();   // R1 lower bound legal, R2 max doublings
        launch(32'd3124999);   drain();   // R1 just below
        launch(32'd220000000); drain();   // R1 upper bound legal
        launch(32'd220000001); drain();   // R1 just above
        launch(32'd100000000); drain();   // R2 no doubling
        launch(32'd99999999);  drain();   // R2 one doubling
        launch(32'd65000000);  drain();
        launch(32'd40000000);  drain();
        launch(32'd150000000); drain();   // R5 coarse range candidates
        launch(32'd108000000); drain();
        launch(32'd0);         drain();
        launch(32'hFFFF_FFFF); drain();

        // R10: second start during the search is ignored
        launch(32'd74250000);
        repeat (30) @(negedge clk);
        target_hz = 32'd40000000;
        start     = 1'b1;
        @(negedge clk);
        start     = 1'b0;
        repeat (100) @(negedge clk);
        target_hz = 32'd5000000;
        start     = 1'b1;
        @(negedge clk);
        start     = 1'b0;
        drain();
        repeat (400) @(negedge clk);
        chk("R10 done count", done_seen, launches);

        // R9: outputs hold after done
        chk("R9 hold m_code", int'(m_code), int'(model(64'd74250000).m));

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule